// File: doc/BRIEF.md
# Supply Brown-Out Detector Controller

This block is the digital side of a supply monitor. A separate analog comparator reports, as a single asynchronous bit, whether the supply has dropped below a selectable threshold. The controller holds the threshold code, enables the analog reference and the comparator, and keeps the comparator result hidden until both analog parts have settled. After that it turns the result into either an interrupt pulse or a held reset request.

Software programs two registers through a simple write port. The level register holds a 3-bit threshold code that goes straight to the comparator. The control register holds three bits. One powers the comparator, one powers the reference generator, and one chooses between interrupt routing and reset routing. A fourth bit of the control register is read-only and shows the live, qualified comparison. Two down-counters measure the settle intervals. Both are clocked from a prescaled tick. When a power-on-clear circuit already supplies the reference, a configuration input skips the reference interval. Interrupt masking is done outside this block.

Top module: `lvd_ctrl`

## Requirements
- R1: After a synchronous reset the control readback is 00H, the level code is 0, and ref_en, det_en, irq_pulse and rst_req are all low.
- R2: A control write stores wr_data bit 7 as the detector enable, bit 4 as the reference enable and bit 1 as the mode (1 = reset routing, 0 = interrupt routing). These bits read back at the same positions of ctrl_rd. The other bits read 0, and bit 0 of the write is ignored.
- R3: A level write (wr_sel = 1) stores wr_data bits 2:0 on lvl_code and ignores bits 7:3. A control write leaves lvl_code unchanged.
- R4: The comparator is ignored (flag 0, no interrupt, no reset) until REF_TICKS*TICK_DIV cycles after the reference enable and DET_TICKS*TICK_DIV cycles after the detector enable have both elapsed.
- R5: With por_bypass high, the reference interval is skipped. Only the detector interval gates the comparator, and ref_en may stay low.
- R6: Once settled, ctrl_rd bit 0 follows the synchronized comparator: 1 while the supply is below the threshold and 0 while it is above.
- R7: In interrupt mode with the detector enabled, each new rise of the qualified below condition gives exactly one single-cycle irq_pulse. This includes the rise at the end of settling. rst_req stays low in this mode.
- R8: In reset mode, a new rise of the qualified below condition asserts rst_req. rst_req stays high while the condition lasts and drops once the supply is above the threshold again. No irq_pulse is produced in reset mode.
- R9: Switching into reset mode while the qualified below condition is already true does not assert rst_req.
- R10: Clearing the mode bit drops rst_req, and a switch to interrupt mode with no new rise gives no interrupt. Clearing the detector enable, or writing 00H to the control register, clears the flag and both requests within two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = control, 1 = level |
| wr_data | input | 8 | Write data |
| cmp_below | input | 1 | Asynchronous comparator output, 1 = supply below threshold |
| por_bypass | input | 1 | 1 = reference supplied by power-on-clear, skip its settle interval |
| ctrl_rd | output | 8 | Control readback with the live flag at bit 0 |
| lvl_code | output | 3 | Threshold code to the comparator |
| ref_en | output | 1 | Reference generator enable |
| det_en | output | 1 | Comparator enable |
| irq_pulse | output | 1 | Single-cycle interrupt request |
| rst_req | output | 1 | Held internal reset request |

## Verification
The assertions assume that cmp_below is either steady or changes slowly compared with the clock. They also assume that por_bypass is a static configuration that does not toggle while the detector is running. The stimulus holds every comparator level for several cycles, well beyond the two-flop synchronizer. It changes por_bypass only while both enables are off. Mode and enable writes follow the programming order that software would use, and the single-write shutdown is tested separately.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int DET_BIT  = 7;
  localparam int REF_BIT  = 4;
  localparam int MODE_BIT = 1;
  localparam int FLAG_BIT = 0;
  localparam int LVL_W    = 3;

  typedef enum logic {
    SEL_CTRL  = 1'b0,
    SEL_LEVEL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lvd_settle.sv
module lvd_settle #(
  parameter int TICK_DIV = 1000,
  parameter int TICKS    = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic done
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CW = $clog2(TICKS + 1);

  logic [PW-1:0] pre;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre  <= '0;
      cnt  <= CW'(TICKS);
      done <= 1'b0;
    end else if (!done) begin
      if (pre == PW'(TICK_DIV - 1)) begin
        pre <= '0;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) done <= 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  // R4
  settle_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !done);

  // R4
  settle_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(TICKS));
endmodule

// File: rtl/lvd_ctrl.sv
module lvd_ctrl #(
  parameter int TICK_DIV  = 1000,
  parameter int REF_TICKS = 2000,
  parameter int DET_TICKS = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       cmp_below,
  input  logic       por_bypass,
  output logic [7:0] ctrl_rd,
  output logic [2:0] lvl_code,
  output logic       ref_en,
  output logic       det_en,
  output logic       irq_pulse,
  output logic       rst_req
);
  import lvd_pkg::*;

  logic             mode_rst;
  logic [LVL_W-1:0] lvl_q;
  logic             below_s;
  logic             ref_done, det_done, ref_ok;
  logic             q_below, q_below_d;
  logic             irq_q, rst_q;

  // register write port
  always_ff @(posedge clk) begin
    if (rst) begin
      det_en   <= 1'b0;
      ref_en   <= 1'b0;
      mode_rst <= 1'b0;
      lvl_q    <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_LEVEL) begin
        lvl_q <= wr_data[LVL_W-1:0];
      end else begin
        det_en   <= wr_data[DET_BIT];
        ref_en   <= wr_data[REF_BIT];
        mode_rst <= wr_data[MODE_BIT];
      end
    end
  end

  lvd_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_async(cmp_below), .q(below_s)
  );

  lvd_settle #(.TICK_DIV(TICK_DIV), .TICKS(REF_TICKS)) u_ref_settle (
    .clk(clk), .rst(rst), .en(ref_en), .done(ref_done)
  );

  lvd_settle #(.TICK_DIV(TICK_DIV), .TICKS(DET_TICKS)) u_det_settle (
    .clk(clk), .rst(rst), .en(det_en), .done(det_done)
  );

  assign ref_ok = por_bypass | ref_done;

  // qualified comparison and request generation
  always_ff @(posedge clk) begin
    if (rst) begin
      q_below   <= 1'b0;
      q_below_d <= 1'b0;
      irq_q     <= 1'b0;
      rst_q     <= 1'b0;
    end else begin
      q_below   <= below_s & det_done & ref_ok & det_en;
      q_below_d <= q_below;
      irq_q     <= det_en & ~mode_rst & q_below & ~q_below_d;
      rst_q     <= det_en & mode_rst & q_below & (rst_q | ~q_below_d);
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[DET_BIT]  = det_en;
    ctrl_rd[REF_BIT]  = ref_en;
    ctrl_rd[MODE_BIT] = mode_rst;
    ctrl_rd[FLAG_BIT] = q_below;
  end

  assign lvl_code  = lvl_q;
  assign irq_pulse = irq_q;
  assign rst_req   = rst_q;

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);

  // R7
  irq_mode_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(det_en && !mode_rst));

  // R9
  rst_fresh_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> $past(!q_below_d));

  // R10
  det_off_chk: assert property (@(posedge clk) disable iff (rst)
    !det_en |=> !q_below);

  // R3
  lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_sel) |=> $stable(lvl_code));

  // R8
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_pulse && rst_req));
endmodule

// File: tb/test_lvd_ctrl.sv
module test_lvd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int RT   = 6;
  localparam int DT   = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cmp_below = 1'b0;
  logic       por_bypass = 1'b0;
  logic [7:0] ctrl_rd;
  logic [2:0] lvl_code;
  logic       ref_en, det_en, irq_pulse, rst_req;

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;
  string exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lvd_ctrl #(.TICK_DIV(TDIV), .REF_TICKS(RT), .DET_TICKS(DT)) i_lvd_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmp_below(cmp_below), .por_bypass(por_bypass), .ctrl_rd(ctrl_rd),
    .lvl_code(lvl_code), .ref_en(ref_en), .det_en(det_en),
    .irq_pulse(irq_pulse), .rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic expect_irq(input string req);
    exp_q.push_back(req);
  endtask

  task automatic chk_drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // monitor: every interrupt pulse must match a queued expectation
  always @(negedge clk) begin
    if (!rst && irq_pulse) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7/R8 unexpected irq", 1, 0);
      end else begin
        string r;
        r = exp_q.pop_front();
        chk(1'b1, r, 1, 1);
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    // R1 reset state
    chk(ctrl_rd == 8'h00, "R1 ctrl", ctrl_rd, 8'h00);
    chk(lvl_code == 3'd0, "R1 lvl", lvl_code, 0);
    chk({ref_en, det_en, irq_pulse, rst_req} == 4'b0, "R1 outs",
        {ref_en, det_en, irq_pulse, rst_req}, 0);

    // R2 bit positions
    wr(1'b0, 8'hFF);
    chk(ctrl_rd == 8'h92, "R2 readback", ctrl_rd, 8'h92);
    chk(ref_en && det_en, "R2 enables", {ref_en, det_en}, 3);
    chk(lvl_code == 3'd0, "R3 ctrl write keeps lvl", lvl_code, 0);
    wr(1'b0, 8'h00);
    chk(ctrl_rd == 8'h00, "R2 cleared", ctrl_rd, 0);

    // R3 level register
    wr(1'b1, 8'hFD);
    chk(lvl_code == 3'd5, "R3 lvl", lvl_code, 5);

    // R4 settle gating, supply already below
    cmp_below = 1'b1;
    wr(1'b0, 8'h10);
    wait_cyc(10);
    wr(1'b0, 8'h90);
    wait_cyc(5);
    chk(ctrl_rd[0] == 1'b0, "R4 flag held during settle", ctrl_rd[0], 0);
    chk(exp_q.size() == 0, "R4 no early irq", 0, 0);
    expect_irq("R7 irq at end of settle");
    wait_cyc(40);
    chk(ctrl_rd[0] == 1'b1, "R4/R6 flag after settle", ctrl_rd[0], 1);
    chk_drained("R7 settle irq seen");

    // R6 flag tracks comparator
    cmp_below = 1'b0;
    wait_cyc(6);
    chk(ctrl_rd[0] == 1'b0, "R6 flag above", ctrl_rd[0], 0);

    // R7 interrupt per fresh fall
    expect_irq("R7 fall one");
    cmp_below = 1'b1;
    wait_cyc(6);
    chk_drained("R7 fall one seen");
    chk(rst_req == 1'b0, "R7 no rst in irq mode", rst_req, 0);
    cmp_below = 1'b0;
    wait_cyc(6);
    expect_irq("R7 fall two");
    cmp_below = 1'b1;
    wait_cyc(6);
    chk_drained("R7 fall two seen");

    // R9 switch to reset mode while below
    wr(1'b0, 8'h92);
    wait_cyc(10);
    chk(rst_req == 1'b0, "R9 no rst on mode switch", rst_req, 0);

    // R8 fresh fall in reset mode
    cmp_below = 1'b0;
    wait_cyc(6);
    cmp_below = 1'b1;
    wait_cyc(6);
    chk(rst_req == 1'b1, "R8 rst on fall", rst_req, 1);
    wait_cyc(10);
    chk(rst_req == 1'b1, "R8 rst held", rst_req, 1);
    cmp_below = 1'b0;
    wait_cyc(6);
    chk(rst_req == 1'b0, "R8 rst released", rst_req, 0);
    cmp_below = 1'b1;
    wait_cyc(6);
    chk(rst_req == 1'b1, "R8 rst again", rst_req, 1);

    // R10 ordered shutdown
    wr(1'b0, 8'h90);
    wait_cyc(3);
    chk(rst_req == 1'b0, "R10 mode cleared drops rst", rst_req, 0);
    wr(1'b0, 8'h10);
    wait_cyc(2);
    chk(ctrl_rd[0] == 1'b0, "R10 det off clears flag", ctrl_rd[0], 0);
    wr(1'b0, 8'h00);
    chk(ctrl_rd == 8'h00, "R10 all off", ctrl_rd, 0);

    // R5 bypass of reference interval
    por_bypass = 1'b1;
    wr(1'b0, 8'h80);
    wait_cyc(4);
    chk(ctrl_rd[0] == 1'b0, "R5 det interval still gates", ctrl_rd[0], 0);
    expect_irq("R5 irq with bypass");
    wait_cyc(16);
    chk(ctrl_rd[0] == 1'b1 && ref_en == 1'b0, "R5 flag without ref", ctrl_rd[0], 1);
    chk_drained("R5 irq seen");

    // R10 single-write shutdown from reset mode
    wr(1'b0, 8'h82);
    cmp_below = 1'b0;
    wait_cyc(6);
    cmp_below = 1'b1;
    wait_cyc(6);
    chk(rst_req == 1'b1, "R8 rst with bypass", rst_req, 1);
    wr(1'b0, 8'h00);
    wait_cyc(2);
    chk(rst_req == 1'b0 && ctrl_rd == 8'h00, "R10 write 00 shutdown",
        {rst_req, ctrl_rd}, 0);
    wait_cyc(10);
    chk_drained("R10 no stray irq");

    wr(1'b1, 8'h03);
    chk(lvl_code == 3'd3, "R3 lvl rewrite", lvl_code, 3);

    finish_run();
  end
endmodule